// File: doc/BRIEF.md
# Low-Power Sleep and Wake-Event Controller

This block decides when a processor core may stop and when it must resume. The core raises a wait-for-event or a wait-for-interrupt request, or signals that it is leaving an interrupt handler and going back to thread code. The block then drives either a light-sleep or a deep-sleep output and holds it until a suitable wake source shows up. When one does, the block drops the sleep output and gives the core a single-cycle wake pulse.

Three control bits sit in a single memory-mapped word:
- **Sleep-on-exit** puts the core back to sleep automatically when a handler returns to thread mode.
- **Deep-sleep select** picks which of the two low-power outputs is used.
- **Wake-on-any-pending** makes pending interrupts count as wake sources even when their enable bit is clear.

A one-bit event latch remembers wake events that arrive while the core is not waiting for one. The next wait-for-event request consumes the latch and returns at once instead of sleeping.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After reset, all three control bits read as zero, the event latch is clear, `sleep_o`, `deep_sleep_o` and `wake_o` are low, and the block is running.
- R2: The control word lives at address `CTRL_ADDR`. Sleep-on-exit is bit 1, deep-sleep select is bit 2 and wake-on-any-pending is bit 4. All other bits read as zero. Any other address reads as zero, and writes to it change nothing. Read data appears one cycle after the address is presented.
- R3: A `wfe_req` with the latch clear and no wake event in that cycle enters sleep. With deep-sleep select at 0, `sleep_o` is high from the next cycle on.
- R4: With deep-sleep select at 1, any entry into sleep drives `deep_sleep_o` instead of `sleep_o`.
- R5: During wait-for-event sleep, any of the following wakes the core: a `sev_pulse`, a rising edge of `ext_event`, or a qualified interrupt becoming pending. In the cycle after the event is sampled, both sleep outputs are low and `wake_o` is high.
- R6: A wake event seen while the core is not in wait-for-event sleep sets the latch. A later `wfe_req` then clears the latch, does not sleep and pulses `wake_o`. A second `wfe_req` after that sleeps.
- R7: With wake-on-any-pending at 0, a pending interrupt whose enable bit is 0 neither wakes the core nor sets the latch.
- R8: With wake-on-any-pending at 1, a pending interrupt wakes the core even when its enable bit is 0.
- R9: A `wfi_req` sleeps until a qualified interrupt is pending, whatever the state of the latch. If a qualified interrupt is already pending at the request, the block does not sleep and pulses `wake_o`.
- R10: An `exc_return` with sleep-on-exit at 1 enters sleep, which ends only on a qualified pending interrupt. With sleep-on-exit at 0 it has no effect.
- R11: `wake_o` lasts exactly one cycle, and `sleep_o` and `deep_sleep_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| wfe_req | input | 1 | Wait-for-event request, one cycle |
| wfi_req | input | 1 | Wait-for-interrupt request, one cycle |
| sev_pulse | input | 1 | Send-event pulse from the core |
| ext_event | input | 1 | External event, acts on its rising edge |
| irq_pend | input | NUM_IRQ | Per-interrupt pending flags |
| irq_en | input | NUM_IRQ | Per-interrupt enable flags |
| exc_return | input | 1 | Return from handler to thread mode, one cycle |
| sleep_o | output | 1 | Light-sleep request |
| deep_sleep_o | output | 1 | Deep-sleep request |
| wake_o | output | 1 | One-cycle resume pulse |

## Verification
Several properties are checked on every cycle by assertions:
- the wake pulse is one cycle wide;
- the two sleep outputs are mutually exclusive;
- a latched event always cancels a wait-for-event request;
- an event during wait-for-event sleep always ends it within one cycle;
- interrupt-wait sleep persists while no qualified interrupt is pending;
- the control word holds its value without a matching write.

Only the directed scenarios can show the rest:
- the field positions and read-back of the control word;
- that disabled interrupts are filtered or admitted according to the control bit;
- that the latch is ignored by interrupt-wait sleep;
- that sleep-on-exit follows its bit.

// File: rtl/lp_wake_pkg.sv
package lp_wake_pkg;
  typedef enum logic [1:0] {
    PM_RUN      = 2'd0,
    PM_EVT_WAIT = 2'd1,
    PM_IRQ_WAIT = 2'd2
  } pm_state_e;

  typedef struct packed {
    logic evt_on_pend;
    logic deep_sel;
    logic exit_sleep;
  } pm_ctrl_t;

  localparam int BIT_EXIT = 1;
  localparam int BIT_DEEP = 2;
  localparam int BIT_EVTP = 4;
endpackage

// File: rtl/lp_ctrl_reg.sv
module lp_ctrl_reg
  import lp_wake_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output pm_ctrl_t          ctrl
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTRL_ADDR);

  logic              hit;
  logic [DATA_W-1:0] rdata_d;
  logic              unused_wdata_bits;

  assign hit = (addr == HIT_ADDR);
  assign unused_wdata_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (we && hit) begin
      ctrl.exit_sleep  <= wdata[BIT_EXIT];
      ctrl.deep_sel    <= wdata[BIT_DEEP];
      ctrl.evt_on_pend <= wdata[BIT_EVTP];
    end
  end

  always_comb begin
    rdata_d = '0;
    if (hit) begin
      rdata_d[BIT_EXIT] = ctrl.exit_sleep;
      rdata_d[BIT_DEEP] = ctrl.deep_sel;
      rdata_d[BIT_EVTP] = ctrl.evt_on_pend;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rdata_d;
  end

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(we && hit) |=> $stable(ctrl));
endmodule

// File: rtl/lp_wake_sources.sv
module lp_wake_sources #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evt_on_pend,
  input  logic               sev_pulse,
  input  logic               ext_event,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               evt_now,
  output logic               irq_level
);
  logic [NUM_IRQ-1:0] qual;
  logic [NUM_IRQ-1:0] qual_q;
  logic               ext_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_qual
    assign qual[i] = irq_pend[i] & (irq_en[i] | evt_on_pend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_q <= '0;
      ext_q  <= 1'b0;
    end else begin
      qual_q <= qual;
      ext_q  <= ext_event;
    end
  end

  assign irq_level = |qual;
  assign evt_now   = sev_pulse | (ext_event & ~ext_q) | (|(qual & ~qual_q));
endmodule

// File: rtl/lp_sleep_fsm.sv
module lp_sleep_fsm
  import lp_wake_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pm_ctrl_t ctrl,
  input  logic     wfe_req,
  input  logic     wfi_req,
  input  logic     exc_return,
  input  logic     evt_now,
  input  logic     irq_level,
  output logic     sleep_o,
  output logic     deep_sleep_o,
  output logic     wake_o
);
  pm_state_e state_q, state_d;
  logic      latch_q, latch_d;
  logic      mode_q, mode_d;
  logic      wake_d;
  logic      irq_sleep_req;

  assign irq_sleep_req = wfi_req | (exc_return & ctrl.exit_sleep);

  always_comb begin
    state_d = state_q;
    latch_d = latch_q;
    mode_d  = mode_q;
    wake_d  = 1'b0;
    case (state_q)
      PM_RUN: begin
        if (wfe_req) begin
          if (latch_q || evt_now) begin
            latch_d = 1'b0;
            wake_d  = 1'b1;
          end else begin
            state_d = PM_EVT_WAIT;
            mode_d  = ctrl.deep_sel;
          end
        end else begin
          if (evt_now) latch_d = 1'b1;
          if (irq_sleep_req) begin
            if (irq_level) begin
              wake_d = 1'b1;
            end else begin
              state_d = PM_IRQ_WAIT;
              mode_d  = ctrl.deep_sel;
            end
          end
        end
      end
      PM_EVT_WAIT: begin
        if (evt_now) begin
          state_d = PM_RUN;
          wake_d  = 1'b1;
        end
      end
      PM_IRQ_WAIT: begin
        if (evt_now) latch_d = 1'b1;
        if (irq_level) begin
          state_d = PM_RUN;
          wake_d  = 1'b1;
        end
      end
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PM_RUN;
      latch_q      <= 1'b0;
      mode_q       <= 1'b0;
      sleep_o      <= 1'b0;
      deep_sleep_o <= 1'b0;
      wake_o       <= 1'b0;
    end else begin
      state_q      <= state_d;
      latch_q      <= latch_d;
      mode_q       <= mode_d;
      sleep_o      <= (state_d != PM_RUN) && !mode_d;
      deep_sleep_o <= (state_d != PM_RUN) && mode_d;
      wake_o       <= wake_d;
    end
  end

  // R11
  wake_single_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o);

  // R11
  mode_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sleep_o && deep_sleep_o));

  // R6
  latch_consume_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_RUN && wfe_req && latch_q) |=>
      (!latch_q && wake_o && !sleep_o && !deep_sleep_o));

  // R5
  evt_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_EVT_WAIT && evt_now) |=>
      (wake_o && !sleep_o && !deep_sleep_o));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_IRQ_WAIT && !irq_level) |=> (state_q == PM_IRQ_WAIT));
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
  import lp_wake_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int CTRL_ADDR = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               wfe_req,
  input  logic               wfi_req,
  input  logic               sev_pulse,
  input  logic               ext_event,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               exc_return,
  output logic               sleep_o,
  output logic               deep_sleep_o,
  output logic               wake_o
);
  pm_ctrl_t ctrl;
  logic     evt_now;
  logic     irq_level;

  lp_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_reg (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl)
  );

  lp_wake_sources #(.NUM_IRQ(NUM_IRQ)) u_src (
    .clk(clk), .rst(rst), .evt_on_pend(ctrl.evt_on_pend),
    .sev_pulse(sev_pulse), .ext_event(ext_event),
    .irq_pend(irq_pend), .irq_en(irq_en),
    .evt_now(evt_now), .irq_level(irq_level)
  );

  lp_sleep_fsm u_fsm (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .wfe_req(wfe_req), .wfi_req(wfi_req), .exc_return(exc_return),
    .evt_now(evt_now), .irq_level(irq_level),
    .sleep_o(sleep_o), .deep_sleep_o(deep_sleep_o), .wake_o(wake_o)
  );
endmodule

// File: tb/lp_wake_ctrl_bench.sv
module lp_wake_ctrl_bench;
  localparam int NI = 8;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          wfe_req = 1'b0, wfi_req = 1'b0, sev_pulse = 1'b0;
  logic          ext_event = 1'b0, exc_return = 1'b0;
  logic [NI-1:0] irq_pend = '0, irq_en = '0;
  logic          sleep_o, deep_sleep_o, wake_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lp_wake_ctrl #(.NUM_IRQ(NI), .ADDR_W(AW), .DATA_W(DW), .CTRL_ADDR(0)) u_lp_wake_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wfe_req(wfe_req), .wfi_req(wfi_req), .sev_pulse(sev_pulse),
    .ext_event(ext_event), .irq_pend(irq_pend), .irq_en(irq_en),
    .exc_return(exc_return), .sleep_o(sleep_o),
    .deep_sleep_o(deep_sleep_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // outputs packed as {sleep, deep, wake}
  function automatic logic [31:0] outs();
    return {29'd0, sleep_o, deep_sleep_o, wake_o};
  endfunction

  task automatic write_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic read_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata; reg_addr = '0;
  endtask

  // 0 wfe, 1 wfi, 2 sev, 3 exc_return; returns at the negedge after sampling
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: wfe_req = 1'b1;
      1: wfi_req = 1'b1;
      2: sev_pulse = 1'b1;
      default: exc_return = 1'b1;
    endcase
    @(negedge clk);
    wfe_req = 1'b0; wfi_req = 1'b0; sev_pulse = 1'b0; exc_return = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 outputs", outs(), 32'h0);
    read_reg(0, d);
    check("R1 ctrl", d, 32'h0);
    pulse(0);                      // latch clear: wfe must sleep
    check("R1 latch clear", outs(), 32'h4);
    pulse(2);
    check("R5 sev wake", outs(), 32'h1);
    @(negedge clk);
    check("R11 wake one cycle", outs(), 32'h0);
  endtask

  task automatic t_register();
    logic [DW-1:0] d;
    write_reg(0, 32'hFFFF_FFFF);
    read_reg(0, d);
    check("R2 field bits", d, 32'h16);
    write_reg(3, 32'h0);
    read_reg(0, d);
    check("R2 other addr write ignored", d, 32'h16);
    read_reg(3, d);
    check("R2 other addr reads zero", d, 32'h0);
    write_reg(0, 32'h0);
  endtask

  task automatic t_wfe_sources();
    pulse(0);
    check("R3 wfe sleep", outs(), 32'h4);
    idle(3);
    check("R3 stays asleep", outs(), 32'h4);
    @(negedge clk); ext_event = 1'b1;
    @(negedge clk);
    check("R5 ext edge wake", outs(), 32'h1);
    idle(2); ext_event = 1'b0;
    irq_en = 8'h01;
    pulse(0);
    check("R3 wfe sleep again", outs(), 32'h4);
    irq_pend = 8'h01;
    @(negedge clk);
    check("R5 irq pend wake", outs(), 32'h1);
    irq_pend = '0; irq_en = '0;
    idle(2);
  endtask

  task automatic t_latch();
    pulse(2);                      // event while running sets latch
    check("R6 no sleep on sev", outs(), 32'h0);
    pulse(0);
    check("R6 wfe consumes latch", outs(), 32'h1);
    pulse(0);
    check("R6 latch cleared then sleep", outs(), 32'h4);
    pulse(2);
    check("R6 wake", outs(), 32'h1);
  endtask

  task automatic t_disabled_irq();
    pulse(0);
    irq_pend = 8'h08; irq_en = 8'h00;
    idle(3);
    check("R7 disabled irq no wake", outs(), 32'h4);
    irq_pend = '0;
    pulse(2);
    check("R7 wake by sev", outs(), 32'h1);
    @(negedge clk); irq_pend = 8'h08;
    @(negedge clk); irq_pend = '0;
    pulse(0);
    check("R7 disabled irq no latch", outs(), 32'h4);
    pulse(2);
    write_reg(0, 32'h10);
    pulse(0);
    check("R8 sleep", outs(), 32'h4);
    irq_pend = 8'h08;
    @(negedge clk);
    check("R8 disabled irq wakes", outs(), 32'h1);
    irq_pend = '0;
    write_reg(0, 32'h0);
  endtask

  task automatic t_wfi();
    pulse(2);                      // latch set
    pulse(1);
    check("R9 wfi ignores latch", outs(), 32'h4);
    idle(2);
    irq_en = 8'h04; irq_pend = 8'h04;
    @(negedge clk);
    check("R9 irq wakes wfi", outs(), 32'h1);
    pulse(1);
    check("R9 pending returns at once", outs(), 32'h1);
    irq_pend = '0; irq_en = '0;
    pulse(0);                      // drain latch (set by irq edge)
    idle(2);
  endtask

  task automatic t_exit();
    pulse(3);
    check("R10 exit off no sleep", outs(), 32'h0);
    write_reg(0, 32'h06);
    pulse(3);
    check("R4 R10 deep on exit", outs(), 32'h2);
    pulse(2);
    check("R10 sev does not end exit sleep", outs(), 32'h2);
    irq_en = 8'h80; irq_pend = 8'h80;
    @(negedge clk);
    check("R10 irq wakes", outs(), 32'h1);
    irq_pend = '0; irq_en = '0;
    pulse(0);                      // drain latch
    pulse(0);
    check("R4 deep on wfe", outs(), 32'h2);
    pulse(2);
    write_reg(0, 32'h0);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_register();
    t_wfe_sources();
    t_latch();
    t_disabled_irq();
    t_wfi();
    t_exit();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule